// File: doc/BRIEF.md
# Read FIFO Drain Width Adapter

This block empties a wide read-data FIFO onto the data output of a processor-bus slave during a burst read. It runs on the fast memory clock. It advances only on memory-clock edges where the sampled level of the half-rate bus clock is 1, so every beat it presents stays on the output for one bus-clock period.

Each FIFO entry is 64 bits wide. When the bus is 32 bits wide, every entry leaves as two beats: the upper half first, then the lower half. When the bus is 64 bits wide, every entry leaves as one beat. The read sequencer starts a transfer by raising a burst-active level and supplying the burst length in bytes. It keeps that level high until the block returns a one-cycle completion pulse, which releases the sequencer from waiting on the FIFO.

Internally, a four-state controller (idle, fetch, upper half, lower half) works with an entry counter that is loaded from the byte length. A lane multiplexer, chosen at elaboration by the bus-width parameter, selects which bits of the FIFO entry drive the output.

Top module: `rfifo_drain_adapter`

## Requirements
- R1: After a synchronous active-low reset, `bus_beat_vld`, `fifo_pop` and `xfer_done` are 0 and `bus_data` is all zeros.
- R2: The controller leaves idle only when `burst_act` is 1 and the FIFO is non-empty. While `burst_act` is 0, FIFO entries are neither popped nor presented.
- R3: With `BUS_W` = 32, each 64-bit entry is presented as two beats: bits [63:32] first, then bits [31:0].
- R4: With `BUS_W` = 64, each entry is presented as a single beat that carries the whole entry.
- R5: A beat is held while the sampled bus-clock level is 0: `bus_beat_vld` stays 1 and `bus_data` stays unchanged. The beat completes at the first memory-clock edge at which the level is 1.
- R6: `fifo_pop` is 1 for exactly one cycle per entry. That cycle is the one in which the entry's final beat completes (valid beat and bus-clock level 1). It is never 1 when the FIFO is empty.
- R7: The number of entries transferred equals `burst_len` divided by 8 (bytes per entry). `burst_len` is a non-zero multiple of 8, at most 128, and is sampled when the controller leaves idle.
- R8: `xfer_done` is a one-cycle pulse in the cycle after the pop of the burst's last entry. No beat is presented in that cycle.
- R9: If the FIFO runs empty in the middle of a burst, no beat is presented until the next entry arrives.
- R10: Whenever `bus_beat_vld` is 0, `bus_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk_lvl | input | 1 | Sampled level of the half-rate bus clock |
| burst_act | input | 1 | Burst read in progress, held by the read sequencer |
| burst_len | input | LEN_W | Burst length in bytes |
| fifo_empty | input | 1 | Read FIFO holds no entry |
| fifo_rdata | input | FIFO_W | Head entry of the read FIFO (show-ahead) |
| fifo_pop | output | 1 | Removes the head entry at the next edge |
| bus_data | output | BUS_W | Beat data toward the bus slave |
| bus_beat_vld | output | 1 | A beat is on `bus_data` |
| xfer_done | output | 1 | One-cycle pulse when the burst has been drained |

## Verification
The assertions assume two things about the inputs. First, the FIFO head entry does not change unless the block pops it. Second, `burst_len` is a legal non-zero multiple of the entry size. The bench's FIFO model appends only at the tail, moves its head only on `fifo_pop`, and is given lengths of 1 to 16 entries. The bench holds `burst_act` high from before the first pop until it sees the completion pulse. It pushes the next burst's data only after it has dropped that level. It drives the bus-clock level with a regular toggle, a stretched pattern (high one cycle in four) and a constant high, so that the pacing rule is exercised under each kind of input.

// File: rtl/drain_pkg.sv
// Shared types for the read FIFO drain adapter.
// Assumes: states are encoded in two bits; the encoding has no external meaning.
package drain_pkg;

    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_FETCH = 2'd1,
        DR_UPPER = 2'd2,
        DR_LOWER = 2'd3
    } drain_state_e;

    // True for the states in which a beat sits on the output.
    function automatic logic is_beat(drain_state_e s);
        return (s == DR_UPPER) || (s == DR_LOWER);
    endfunction

endpackage

// File: rtl/drain_entry_counter.sv
// Counts the FIFO entries still owed in the current burst.
// Assumes: burst_len is a non-zero multiple of the entry size in bytes;
// load and dec never coincide.
module drain_entry_counter #(
    parameter int LEN_W = 8,
    parameter int SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             dec,
    output logic             last_entry
);

    logic [LEN_W-1:0] remaining;

    // Load the entry count from the byte length, then step down once per pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= burst_len >> SHIFT;
        end else if (dec && (remaining != '0)) begin
            remaining <= remaining - 1'b1;
        end
    end

    // The current entry is the last one when at most one is outstanding.
    always_comb begin
        last_entry = (remaining <= {{(LEN_W-1){1'b0}}, 1'b1});
    end

endmodule

// File: rtl/drain_ctrl_fsm.sv
// Four-state drain controller: idle, fetch, upper half, lower half.
// Every move out of fetch, upper or lower waits for a sampled bus-clock
// level of 1. SPLIT selects the two-beat (narrow bus) path through the
// upper-half state.
// Assumes: the FIFO head is show-ahead and stays stable until popped.
module drain_ctrl_fsm
    import drain_pkg::*;
#(
    parameter bit SPLIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         burst_act,
    input  logic         fifo_empty,
    input  logic         bus_lvl,
    input  logic         last_entry,
    output drain_state_e state,
    output logic         cnt_load,
    output logic         entry_pop,
    output logic         done_pulse
);

    drain_state_e nxt;
    logic         finish;

    // Next state, counter load and pop strobe.
    always_comb begin
        nxt       = state;
        cnt_load  = 1'b0;
        entry_pop = 1'b0;
        finish    = 1'b0;
        unique case (state)
            DR_IDLE: begin
                if (burst_act && !fifo_empty) begin
                    nxt      = DR_FETCH;
                    cnt_load = 1'b1;
                end
            end
            DR_FETCH: begin
                if (!fifo_empty && bus_lvl) begin
                    nxt = SPLIT ? DR_UPPER : DR_LOWER;
                end
            end
            DR_UPPER: begin
                if (bus_lvl) begin
                    nxt = DR_LOWER;
                end
            end
            DR_LOWER: begin
                if (bus_lvl) begin
                    entry_pop = 1'b1;
                    if (last_entry) begin
                        nxt    = DR_IDLE;
                        finish = 1'b1;
                    end else begin
                        nxt = DR_FETCH;
                    end
                end
            end
            default: nxt = DR_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DR_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Completion pulse, one cycle, on the return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= finish;
        end
    end

endmodule

// File: rtl/drain_lane_mux.sv
// Selects the bits of the FIFO entry that go onto the bus for the current
// state. The narrow variant sends the upper half in the upper-half state and
// the lower half in the lower-half state; the whole variant sends the full
// entry in the lower-half state. Output is zero outside a beat.
// Assumes: FIFO_W equals BUS_W or twice BUS_W.
module drain_lane_mux
    import drain_pkg::*;
#(
    parameter int FIFO_W = 64,
    parameter int BUS_W  = 32
) (
    input  drain_state_e      state,
    input  logic [FIFO_W-1:0] fifo_word,
    output logic [BUS_W-1:0]  beat_data,
    output logic              beat_vld
);

    generate
        if (FIFO_W == 2 * BUS_W) begin : g_split
            // Upper half first, lower half second.
            always_comb begin
                unique case (state)
                    DR_UPPER: beat_data = fifo_word[FIFO_W-1 -: BUS_W];
                    DR_LOWER: beat_data = fifo_word[BUS_W-1:0];
                    default:  beat_data = '0;
                endcase
            end
        end else begin : g_whole
            // One beat per entry.
            always_comb begin
                beat_data = (state == DR_LOWER) ? fifo_word[BUS_W-1:0] : '0;
            end
        end
    endgenerate

    // A beat is valid in either output state.
    always_comb begin
        beat_vld = is_beat(state);
    end

endmodule

// File: rtl/rfifo_drain_adapter.sv
// Drains burst-read data from a 64-bit show-ahead FIFO onto a processor-bus
// slave data output of BUS_W bits, pacing each beat to the sampled level of
// the half-rate bus clock, and pulses xfer_done when the burst is drained.
// Assumes: burst_act stays high from burst start until xfer_done; burst_len
// is a non-zero multiple of FIFO_W/8 no larger than MAX_BURST_BYTES.
module rfifo_drain_adapter
    import drain_pkg::*;
#(
    parameter int FIFO_W          = 64,
    parameter int BUS_W           = 32,
    parameter int MAX_BURST_BYTES = 128,
    parameter int LEN_W           = $clog2(MAX_BURST_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_lvl,
    input  logic              burst_act,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic              fifo_empty,
    input  logic [FIFO_W-1:0] fifo_rdata,
    output logic              fifo_pop,
    output logic [BUS_W-1:0]  bus_data,
    output logic              bus_beat_vld,
    output logic              xfer_done
);

    localparam int ENTRY_BYTES = FIFO_W / 8;
    localparam int SHIFT       = $clog2(ENTRY_BYTES);
    localparam bit SPLIT       = (FIFO_W == 2 * BUS_W);

    drain_state_e st;
    logic         cnt_load;
    logic         last_entry;

    drain_ctrl_fsm #(
        .SPLIT (SPLIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_act  (burst_act),
        .fifo_empty (fifo_empty),
        .bus_lvl    (bus_clk_lvl),
        .last_entry (last_entry),
        .state      (st),
        .cnt_load   (cnt_load),
        .entry_pop  (fifo_pop),
        .done_pulse (xfer_done)
    );

    drain_entry_counter #(
        .LEN_W (LEN_W),
        .SHIFT (SHIFT)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .burst_len  (burst_len),
        .dec        (fifo_pop),
        .last_entry (last_entry)
    );

    drain_lane_mux #(
        .FIFO_W (FIFO_W),
        .BUS_W  (BUS_W)
    ) u_mux (
        .state     (st),
        .fifo_word (fifo_rdata),
        .beat_data (bus_data),
        .beat_vld  (bus_beat_vld)
    );

endmodule

// File: rtl/drain_checker.sv
// Port-level properties of the drain adapter, bound into every instance.
// Assumes: the FIFO head changes only after a pop.
module drain_checker #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_clk_lvl,
    input logic             fifo_empty,
    input logic             fifo_pop,
    input logic [BUS_W-1:0] bus_data,
    input logic             bus_beat_vld,
    input logic             xfer_done
);

    // R5
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_beat_vld && !bus_clk_lvl) |=> (bus_beat_vld && $stable(bus_data)));

    // R6
    pop_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (bus_beat_vld && bus_clk_lvl));

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R8
    done_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(fifo_pop));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !bus_beat_vld);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_beat_vld |-> (bus_data == '0));

endmodule

bind rfifo_drain_adapter drain_checker #(
    .BUS_W (BUS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_clk_lvl  (bus_clk_lvl),
    .fifo_empty   (fifo_empty),
    .fifo_pop     (fifo_pop),
    .bus_data     (bus_data),
    .bus_beat_vld (bus_beat_vld),
    .xfer_done    (xfer_done)
);

// File: tb/drain_harness.sv
`timescale 1ns/1ps
// Per-width harness: FIFO model, bus-clock level generator, driver that
// queues expected beats, and a monitor that pops and compares them.
module drain_harness #(
    parameter int    BUS_W = 32,
    parameter string TAG   = "bus32"
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic finished,
    output int   n_cmp,
    output int   n_bad
);

    localparam int LEN_W = 8;

    logic             bus_clk_lvl = 1'b0;
    logic             burst_act   = 1'b0;
    logic [LEN_W-1:0] burst_len   = '0;
    logic             fifo_empty;
    logic [63:0]      fifo_rdata;
    logic             fifo_pop;
    logic [BUS_W-1:0] bus_data;
    logic             bus_beat_vld;
    logic             xfer_done;

    logic [63:0] fmem [0:31];
    logic [5:0]  wp = '0;
    logic [5:0]  rp;
    logic [63:0] emem [0:511];
    int ew = 0;
    int er = 0;
    int lvl_mode = 0;
    int lvl_cnt  = 0;
    int pop_target = 0;
    int pop_pred   = 0;
    int done_seen  = 0;
    bit pend_done  = 1'b0;
    bit hold_prev  = 1'b0;
    bit half       = 1'b0;
    logic [BUS_W-1:0] held = '0;
    int cmp_d = 0, bad_d = 0, cmp_m = 0, bad_m = 0;

    assign n_cmp      = cmp_d + cmp_m;
    assign n_bad      = bad_d + bad_m;
    assign fifo_empty = (wp == rp);
    assign fifo_rdata = fmem[rp[4:0]];

    rfifo_drain_adapter #(
        .FIFO_W (64),
        .BUS_W  (BUS_W),
        .MAX_BURST_BYTES (128),
        .LEN_W  (LEN_W)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_clk_lvl  (bus_clk_lvl),
        .burst_act    (burst_act),
        .burst_len    (burst_len),
        .fifo_empty   (fifo_empty),
        .fifo_rdata   (fifo_rdata),
        .fifo_pop     (fifo_pop),
        .bus_data     (bus_data),
        .bus_beat_vld (bus_beat_vld),
        .xfer_done    (xfer_done)
    );

    // Bus-clock level patterns: 0 toggle, 1 high one cycle in four, else high.
    always @(negedge clk) begin
        lvl_cnt <= lvl_cnt + 1;
        case (lvl_mode)
            0:       bus_clk_lvl <= ~bus_clk_lvl;
            1:       bus_clk_lvl <= ((lvl_cnt % 4) == 3);
            default: bus_clk_lvl <= 1'b1;
        endcase
    end

    // FIFO head moves only on a pop.
    always @(posedge clk) begin
        if (!rst_n) rp <= '0;
        else if (fifo_pop) rp <= rp + 1'b1;
    end

    task automatic chk_m(input bit ok, input string r, input logic [63:0] a, input logic [63:0] e);
        cmp_m++;
        if (!ok) begin
            bad_m++;
            $display("FAIL [%s] %s: actual %h expected %h", TAG, r, a, e);
        end
    endtask

    task automatic chk_d(input bit ok, input string r, input logic [63:0] a, input logic [63:0] e);
        cmp_d++;
        if (!ok) begin
            bad_d++;
            $display("FAIL [%s] %s: actual %h expected %h", TAG, r, a, e);
        end
    endtask

    // Monitor: compares completed beats against the expected queue.
    always @(negedge clk) begin
        bit exp_pop;
        bit nxt_pend;
        #1;
        if (rst_n && start) begin
            nxt_pend = 1'b0;
            chk_m(xfer_done == pend_done, "R8 done pulse", 64'(xfer_done), 64'(pend_done));
            if (xfer_done) done_seen++;
            if (hold_prev)
                chk_m(bus_beat_vld && (bus_data == held), "R5 beat held",
                      64'(bus_data), 64'(held));
            if (bus_beat_vld && bus_clk_lvl) begin
                exp_pop = (BUS_W == 64) ? 1'b1 : half;
                chk_m((er < ew) && (bus_data == emem[er % 512][BUS_W-1:0]),
                      (BUS_W == 32) ? "R3 split beat" : "R4 whole beat",
                      64'(bus_data), emem[er % 512]);
                er++;
                chk_m(fifo_pop == exp_pop, "R6 pop on final beat", 64'(fifo_pop), 64'(exp_pop));
                if (exp_pop) begin
                    pop_pred++;
                    if (pop_pred == pop_target) nxt_pend = 1'b1;
                end
                half = ~half;
            end else begin
                chk_m(!fifo_pop, "R6 no pop off edge", 64'(fifo_pop), 64'd0);
                if (!bus_beat_vld)
                    chk_m(bus_data == '0, "R10 idle data zero", 64'(bus_data), 64'd0);
            end
            pend_done = nxt_pend;
            hold_prev = bus_beat_vld && !bus_clk_lvl;
            held      = bus_data;
        end
    end

    function automatic logic [63:0] word_of(input int b, input int i);
        return {16'(b), 16'(i), 16'(~b), 16'(i * 16'h0f0f + 16'h1234)};
    endfunction

    // Driver: writes the FIFO and queues the beats that must come out.
    task automatic push_entry(input logic [63:0] w);
        fmem[wp[4:0]] = w;
        wp = wp + 1'b1;
        if (BUS_W == 32) begin
            emem[ew % 512] = {32'h0, w[63:32]}; ew++;
            emem[ew % 512] = {32'h0, w[31:0]};  ew++;
        end else begin
            emem[ew % 512] = w; ew++;
        end
    endtask

    task automatic run_burst(input int n, input int gap, input int hold, input int mode, input int bid);
        int rp0;
        int d0;
        lvl_mode = mode;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (gap == 0 || i == 0) push_entry(word_of(bid, i));
        end
        rp0 = int'(rp);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk); #2;
            chk_d(!bus_beat_vld && (int'(rp) == rp0), "R2 idle without burst_act",
                  64'(rp), 64'(rp0));
        end
        pop_target = pop_target + n;
        d0 = done_seen;
        @(negedge clk);
        burst_len = LEN_W'(n * 8);
        burst_act = 1'b1;
        if (gap > 0) begin
            for (int i = 1; i < n; i++) begin
                while (wp != rp) @(negedge clk);
                for (int k = 0; k < gap; k++) begin
                    @(negedge clk); #2;
                    chk_d(!bus_beat_vld && !fifo_pop, "R9 wait on empty FIFO",
                          64'(bus_beat_vld), 64'd0);
                end
                @(negedge clk);
                push_entry(word_of(bid, i));
            end
        end
        while (done_seen == d0) @(negedge clk);
        burst_act = 1'b0;
        chk_d(rp == wp, "R7 all entries popped", 64'(rp), 64'(wp));
        chk_d(er == ew, "R7 all beats delivered", 64'(er), 64'(ew));
    endtask

    initial begin
        finished = 1'b0;
        wait (start);
        @(negedge clk); #2;
        chk_d(!bus_beat_vld, "R1 reset valid", 64'(bus_beat_vld), 64'd0);
        chk_d(!fifo_pop,     "R1 reset pop",   64'(fifo_pop), 64'd0);
        chk_d(!xfer_done,    "R1 reset done",  64'(xfer_done), 64'd0);
        chk_d(bus_data == '0, "R1 reset data", 64'(bus_data), 64'd0);
        run_burst(2, 0, 8, 0, 1);    // R2: entries wait for burst_act
        run_burst(16, 0, 0, 0, 2);   // R7: longest burst, 128 bytes
        run_burst(4, 0, 0, 1, 3);    // R5: stretched bus clock
        run_burst(3, 3, 0, 0, 4);    // R9: FIFO underflow gaps
        run_burst(1, 0, 0, 2, 5);    // R8: single entry, level held high
        run_burst(5, 2, 2, 1, 6);    // mixed
        repeat (4) @(negedge clk);
        finished = 1'b1;
    end

endmodule

// File: tb/tb_rfifo_drain_adapter.sv
`timescale 1ns/1ps
// Top bench: runs the narrow-bus and wide-bus harnesses side by side.
module tb_rfifo_drain_adapter;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic f32, f64;
    int   c32, b32, c64, b64;

    always #2.5 clk = ~clk;

    drain_harness #(.BUS_W(32), .TAG("bus32")) h32 (
        .clk (clk), .rst_n (rst_n), .start (start),
        .finished (f32), .n_cmp (c32), .n_bad (b32)
    );

    drain_harness #(.BUS_W(64), .TAG("bus64")) h64 (
        .clk (clk), .rst_n (rst_n), .start (start),
        .finished (f64), .n_cmp (c64), .n_bad (b64)
    );

    initial begin
        int cyc;
        int wd_cmp;
        int wd_bad;
        cyc    = 0;
        wd_cmp = 0;
        wd_bad = 0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b1;
        while (!(f32 && f64) && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        wd_cmp = 1;
        if (!(f32 && f64)) begin
            wd_bad = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 c32 + c64 + wd_cmp, b32 + b64 + wd_bad);
        $finish;
    end

endmodule